// File: doc/BRIEF.md
# Staggered Frequency Word Loader

This block takes a 32-bit frequency control word from a writer that runs with no relation to the system clock and hands it to a phase accumulator built in 8-bit sections with a registered carry between sections. The writer sets up the word and then releases an active-low write strobe. The strobe's rising edge latches the word into a holding register. That register is clocked by the strobe itself.

In the system clock domain, the strobe passes through a two-flop synchronizer. The two synchronizer stages are compared to give a single-cycle load pulse. The pulse then moves along a short chain of flops, one stage per clock. Stage k of the chain copies byte lane k of the held word into the synchronous output, starting with the least significant lane. An update therefore reaches each accumulator section in the same cycle as the carry from the section below it.

If a new write arrives before an update has finished, a new sequence starts. The old sequence runs to its end. Because lanes always copy the current contents of the holding register, every lane ends up with the newest word.

Top module: `freq_word_loader`

## Requirements
- R1: While reset is low at a clock edge, the synchronous output becomes zero after that edge. A load sequence that was in progress when reset came is abandoned, so the output stays zero afterwards.
- R2: The input word is sampled only at the rising edge of the write strobe. Changes to the input word at any other time do not reach the output.
- R3: Call the first rising clock edge after the strobe's rising edge edge 1. Byte lane k (bits 8k+7 down to 8k, with k from 0 to 3) takes the captured byte at edge 3+k. Lane 0 is updated at edge 3 and lane 3 at edge 6.
- R4: One write changes each lane at its own edge only. In every other cycle that lane holds its value.
- R5: A falling strobe, a strobe held low, and a strobe that is high when reset is released all leave the output unchanged.
- R6: A second write whose strobe rises while an earlier update is still under way starts a new sequence. Each lane takes the holding register value that is current at that lane's edge, and after the new sequence completes all four lanes hold the newest word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset, synchronous in the clock domain, also clears the holding register |
| word_wr_ni | input | 1 | Active-low write strobe, asynchronous; its rising edge captures the word |
| word_i | input | 32 | Frequency control word from the writer |
| sync_word_o | output | 32 | Staggered synchronous frequency word |

## Verification
Each lane's result is due a fixed number of clock edges after the strobe rises: lane 0 at the third rising clock edge and each higher lane one edge later. The bench places every strobe rise at an offset inside a clock period, well away from any edge, so the first edge is known without doubt. It then counts edges and samples the whole output at the falling clock edge after each one, comparing against a word assembled from old and new bytes for that exact edge. The restart and mid-sequence reset cases are worked out the same way, including the lane that picks up the second word early.

// File: rtl/fwl_pkg.sv
// Shared constants for the staggered frequency word loader.
// Assumes the word width is a whole multiple of the lane width.
package fwl_pkg;
    localparam int unsigned FWL_WORD_W = 32;
    localparam int unsigned FWL_LANE_W = 8;

    // Number of byte lanes for a given word and lane width.
    function automatic int unsigned fwl_lanes(input int unsigned word_w,
                                              input int unsigned lane_w);
        return word_w / lane_w;
    endfunction
endpackage

// File: rtl/fwl_capture.sv
// Holding register clocked by the rising edge of the active-low write strobe.
// Assumes the writer keeps the word stable around that edge. The register
// lives in the strobe domain, so reset acts on it asynchronously.
module fwl_capture #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             strobe_ni,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] hold_o
);
    // Latch the word when the strobe returns high.
    always_ff @(posedge strobe_ni or negedge rst_ni) begin
        if (!rst_ni) hold_o <= '0;
        else         hold_o <= data_i;
    end
endmodule

// File: rtl/fwl_edge_sync.sv
// Brings the asynchronous strobe into the clock domain through two flops and
// makes a one-cycle pulse on its rising edge. Both stages reset high, matching
// an idle strobe, so releasing reset cannot create a false pulse.
module fwl_edge_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic strobe_ni,
    output logic pulse_o
);
    logic meta_q;
    logic sync_q;

    // Two-stage synchronizer of the raw strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= strobe_ni;
            sync_q <= meta_q;
        end
    end

    // Rising edge: the first stage is already high, the second still low.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) pulse_o <= 1'b0;
        else         pulse_o <= meta_q & ~sync_q;
    end
endmodule

// File: rtl/fwl_pulse_chain.sv
// Delays the load pulse through NUM_LANES-1 flops, one stage per lane.
// Stage 0 is the incoming pulse itself.
module fwl_pulse_chain #(
    parameter int unsigned NUM_LANES = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 pulse_i,
    output logic [NUM_LANES-1:0] load_o
);
    assign load_o[0] = pulse_i;

    for (genvar k = 1; k < NUM_LANES; k++) begin : g_stage
        // Move the pulse one lane up per clock.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) load_o[k] <= 1'b0;
            else         load_o[k] <= load_o[k-1];
        end
    end
endmodule

// File: rtl/fwl_lane_bank.sv
// Synchronous output lanes. Each lane copies its slice of the holding
// register when its own load pulse is high.
module fwl_lane_bank #(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned LANE_W    = 8,
    localparam int unsigned WORD_W   = NUM_LANES * LANE_W
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_LANES-1:0] load_i,
    input  logic [WORD_W-1:0]    hold_i,
    output logic [WORD_W-1:0]    word_o
);
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        // Update lane k on its pulse, otherwise keep it.
        always_ff @(posedge clk_i) begin
            if (!rst_ni)
                word_o[k*LANE_W +: LANE_W] <= '0;
            else if (load_i[k])
                word_o[k*LANE_W +: LANE_W] <= hold_i[k*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/freq_word_loader.sv
// Top level: captures a word on the asynchronous strobe and releases it into
// the clock domain one byte lane per cycle, lowest lane first.
// Assumes the strobe stays low and stays high for at least two clock periods
// each time, so that the synchronizer sees every level.
module freq_word_loader
    import fwl_pkg::*;
#(
    parameter int unsigned WORD_W = FWL_WORD_W,
    parameter int unsigned LANE_W = FWL_LANE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              word_wr_ni,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] sync_word_o
);
    localparam int unsigned NUM_LANES = fwl_lanes(WORD_W, LANE_W);

    logic [WORD_W-1:0]    hold_q;
    logic                 edge_pulse;
    logic [NUM_LANES-1:0] load_pulse;

    fwl_capture #(.WIDTH(WORD_W)) u_capture (
        .strobe_ni (word_wr_ni),
        .rst_ni    (rst_ni),
        .data_i    (word_i),
        .hold_o    (hold_q)
    );

    fwl_edge_sync u_edge (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .strobe_ni (word_wr_ni),
        .pulse_o   (edge_pulse)
    );

    fwl_pulse_chain #(.NUM_LANES(NUM_LANES)) u_chain (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pulse_i (edge_pulse),
        .load_o  (load_pulse)
    );

    fwl_lane_bank #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_lanes (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load_pulse),
        .hold_i (hold_q),
        .word_o (sync_word_o)
    );
endmodule

// File: rtl/fwl_checker.sv
// Properties of the loader, attached to every instance of the top by bind.
module fwl_checker #(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned LANE_W    = 8,
    localparam int unsigned WORD_W   = NUM_LANES * LANE_W
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [WORD_W-1:0]    hold_q,
    input logic [NUM_LANES-1:0] load_pulse,
    input logic [WORD_W-1:0]    sync_word_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk_i) !rst_ni |=> sync_word_o == '0); // R1

    AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_pulse[0] |=> !load_pulse[0]); // R3

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_chk
        AST_LANE_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
            load_pulse[k] |=> sync_word_o[k*LANE_W +: LANE_W] == $past(hold_q[k*LANE_W +: LANE_W])); // R3
        AST_LANE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !load_pulse[k] |=> $stable(sync_word_o[k*LANE_W +: LANE_W])); // R4
        if (k > 0) begin : g_step
            AST_CHAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
                load_pulse[k-1] |=> load_pulse[k]); // R3
        end
    end
endmodule

bind freq_word_loader fwl_checker #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_fwl_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_q      (hold_q),
    .load_pulse  (load_pulse),
    .sync_word_o (sync_word_o)
);

// File: tb/freq_word_loader_bench.sv
`timescale 1ns/100ps
module freq_word_loader_bench;
    localparam int NV = 8;
    localparam logic [31:0] VEC_WORD [NV] = '{
        32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0001, 32'hA5A5_5A5A,
        32'h8000_0000, 32'h0102_0304, 32'hDEAD_BEEF, 32'h0000_0000};
    // Strobe rise offset after a clock edge, in tenths of a ns (period 4 ns).
    localparam int VEC_OFF [NV] = '{5, 12, 20, 28, 35, 8, 31, 17};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1;
    logic [31:0] word = '0;
    logic [31:0] dout;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    freq_word_loader u_freq_word_loader (
        .clk_i(clk), .rst_ni(rst_n), .word_wr_ni(wr_n),
        .word_i(word), .sync_word_o(dout));

    task automatic check(input logic [31:0] exp, input string req, input string what);
        total++;
        if (dout !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, dout, exp);
        end
    endtask

    // Expected output after edge e of a write from old to new.
    function automatic logic [31:0] mix(input logic [31:0] o, input logic [31:0] n, input int e);
        logic [31:0] r = o;
        for (int k = 0; k < 4; k++)
            if (e >= 3 + k) r[k*8 +: 8] = n[k*8 +: 8];
        return r;
    endfunction

    // Next clock edge, then the falling edge where outputs are sampled.
    task automatic edge_then_sample();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin : wdog
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] prev;
        logic [31:0] a;
        logic [31:0] b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(32'h0, "R1", "reset value");
        rst_n = 1'b1;
        repeat (8) edge_then_sample();
        check(32'h0, "R5", "idle strobe after reset release");

        prev = 32'h0;
        for (int v = 0; v < NV; v++) begin
            @(posedge clk); #1;
            word = ~VEC_WORD[v]; wr_n = 1'b0;
            repeat (2) @(posedge clk);
            #1 word = VEC_WORD[v];
            @(posedge clk);
            #(VEC_OFF[v] / 10.0) wr_n = 1'b1;
            #0.2 word = 32'h5A5A_F00D ^ VEC_WORD[v];  // R2: later changes ignored
            for (int e = 1; e <= 6; e++) begin
                @(posedge clk); @(negedge clk);
                check(mix(prev, VEC_WORD[v], e), "R3/R4", $sformatf("vec %0d edge %0d", v, e));
            end
            repeat (3) edge_then_sample();
            check(VEC_WORD[v], "R2", $sformatf("vec %0d final word", v));
            prev = VEC_WORD[v];
        end

        // Strobe falling and held low: no update (R5).
        @(posedge clk); #1 word = 32'h7777_7777; wr_n = 1'b0;
        repeat (6) edge_then_sample();
        check(prev, "R5", "strobe held low");

        // Restart during an update (R6).
        a = 32'hCAFE_0001; b = 32'h0BAD_F00D;
        word = a;
        @(posedge clk); #1.5 wr_n = 1'b1;          // rise after edge E0
        edge_then_sample(); edge_then_sample();    // E1, E2
        @(posedge clk); #1 wr_n = 1'b0; word = b;  // E3
        @(negedge clk);
        check(mix(prev, a, 3), "R6", "first sequence lane 0");
        edge_then_sample();                        // E4
        @(posedge clk); #1.5 wr_n = 1'b1;          // after E5
        #0.3 word = 32'h1111_2222;
        @(negedge clk);
        check(mix(prev, a, 5), "R6", "first sequence lane 2");
        edge_then_sample();                        // E6: lane 3 picks up b
        check({b[31:24], a[23:0]}, "R6", "lane 3 takes newest word");
        repeat (6) edge_then_sample();
        check(b, "R6", "restart final word");

        // Reset in the middle of a sequence (R1).
        @(posedge clk); #1 wr_n = 1'b0; word = 32'h3C3C_3C3C;
        repeat (2) @(posedge clk);
        #1.5 wr_n = 1'b1;
        repeat (3) edge_then_sample();             // lane 0 updated at E3
        check({b[31:8], 8'h3C}, "R3", "lane 0 before mid reset");
        #0.5 rst_n = 1'b0;
        edge_then_sample();
        check(32'h0, "R1", "reset during sequence");
        #0.5 rst_n = 1'b1;
        repeat (6) edge_then_sample();
        check(32'h0, "R1", "abandoned sequence stays cleared");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule